// File: doc/BRIEF.md
# Memory bus transaction dispatcher

This block sits between the on-chip masters and the external memory bus. A master presents one request at a time. Each request carries a read/write flag, a lock flag, a length in words, a word address and a byte mask. The dispatcher first checks that the length and the starting word offset within a 32-byte line fit together. It then decodes the target region and the DRAM bank, and picks one of five outcomes: protocol error, data abort, silent drop, all-bank refresh, or a sequence of external bus beats.

A locked request is a swap. It becomes one single-word read followed by one single-word write at the same address. No new request is accepted until the write has finished. When a read finds no device selected, it returns the last value seen on the data bus. A single-word access to a disabled DRAM bank is turned into a refresh request for all banks, and no bus cycle is issued.

Top module: `mem_txn_dispatch`

## Requirements
- R1: A read is legal only in these cases: length 1 at any word offset (address bits 2:0); length 4 at offset 0 or 4; length 8 at offset 0. Any other read pulses perr_o for one cycle and issues no bus beat. The length check is applied before the region and bank checks.
- R2: A write is legal only in these cases: length 1 with a nonzero mask; length 2, 3 or 4 where (offset mod 4) + length ≤ 4; length 8 at offset 0. Any other write pulses perr_o for one cycle and issues no bus beat.
- R3: On a single-word write beat, bus_mask_o equals the request mask. On every other beat, bus_mask_o is 4'hF. A write beat never carries a zero mask.
- R4: A locked request (req_lock_i=1, req_write_i ignored) is legal only with length 1 and a nonzero mask. If legal, it produces one read beat, then one write beat at the same address with the request mask. Otherwise it pulses perr_o.
- R5: Address bits [11:10] = 2'b10 mark the reserved region. A read or swap there pulses abort_o. A write there is dropped. In both cases no bus beat is issued.
- R6: A read beat with bus_sel_i=0 returns the last value seen on the data bus. That value is the read data of the most recent read beat with bus_sel_i=1, or the write data of the most recent write beat, whichever came later.
- R7: Region 2'b00 is DRAM, and address bits [9:8] select the bank. If that bank's bank_en_i bit is clear, a single-word access pulses refresh_o with no bus beat. A read or swap also returns rd_valid_o with zero data in the same cycle. A write is dropped.
- R8: A burst read to a disabled bank pulses abort_o. A burst write to a disabled bank is dropped without a refresh. Neither issues a bus beat.
- R9: req_ready_o is high only when no request is in progress. Every accepted request yields exactly one done_o pulse. If the request has bus beats, done_o coincides with the acceptance of its last beat. Otherwise it coincides with the perr_o, abort_o or refresh_o pulse, one cycle after acceptance.
- R10: Burst beats use ascending word addresses starting at the request address. A beat holds its address, direction and mask until bus_ready_i is high. wd_take_o marks each accepted write beat, and wdata_i is driven onto the bus as bus_wdata_o.
- R11: While reset is held, req_ready_o is 1, and bus_valid_o, done_o, perr_o, abort_o, refresh_o and rd_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_lock_i | input | 1 | Locked swap request |
| req_len_i | input | LW (4) | Length in words |
| req_addr_i | input | AW (12) | Word address |
| req_mask_i | input | DW/8 (4) | Byte mask for single-word writes |
| wdata_i | input | DW (32) | Write data for the current beat |
| wd_take_o | output | 1 | Write beat accepted; next data may be presented |
| bank_en_i | input | NBANK (4) | DRAM bank enable bits |
| bus_valid_o | output | 1 | Bus beat valid |
| bus_ready_i | input | 1 | Bus accepts the beat |
| bus_write_o | output | 1 | Beat direction |
| bus_addr_o | output | AW (12) | Beat word address |
| bus_mask_o | output | DW/8 (4) | Beat byte mask |
| bus_wdata_o | output | DW (32) | Beat write data |
| bus_rdata_i | input | DW (32) | Bus read data |
| bus_sel_i | input | 1 | A device answered the read |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DW (32) | Read data to the master |
| abort_o | output | 1 | Data abort pulse |
| perr_o | output | 1 | Illegal length/offset pulse |
| refresh_o | output | 1 | All-bank refresh request pulse |
| done_o | output | 1 | Request complete pulse |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the refresh request and the zero read return for a single read or swap to a disabled bank. The second pair is done_o and the read data of the last beat of a read burst. The bench sweeps every region, bank, length and operation against a bank enable pattern that has both enabled and disabled banks. In every cycle it counts the refresh, abort, error and read-data events and checks each against the expected count. The bus acceptance pattern is run both irregular and always ready, so the last read beat and done_o are judged in the same sample both after stalls and with no stalls.

// File: rtl/mtd_pkg.sv
package mtd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_RD, S_WR, S_LK_RD, S_LK_WR
  } mtd_st_e;

  typedef enum logic [2:0] {
    O_PERR, O_ABORT, O_DROP, O_REFRESH, O_BUS
  } mtd_out_e;
endpackage

// File: rtl/mtd_decode.sv
module mtd_decode
  import mtd_pkg::*;
#(
  parameter int LW       = 4,
  parameter int BW       = 4,
  parameter int NBANK    = 4,
  parameter logic [1:0] RSV_CODE  = 2'b10,
  parameter logic [1:0] DRAM_CODE = 2'b00,
  localparam int BB = $clog2(NBANK)
) (
  input  logic          wr_i,
  input  logic          lock_i,
  input  logic [LW-1:0] len_i,
  input  logic [2:0]    off_i,
  input  logic [1+BB:0] hi_i,
  input  logic [BW-1:0] mask_i,
  input  logic [NBANK-1:0] bank_en_i,
  output mtd_out_e      out_o
);
  logic [LW:0] fit_sum;
  logic        fit4, len_one, rd_ok, wr_ok, legal;
  logic [1:0]  region;
  logic [BB-1:0] bank;
  logic        bank_on, is_rd;

  assign fit_sum = (LW+1)'(off_i[1:0]) + {1'b0, len_i};
  assign fit4    = fit_sum <= (LW+1)'(4);
  assign len_one = len_i == LW'(1);

  assign rd_ok = len_one
              || (len_i == LW'(4) && off_i[1:0] == 2'b00)
              || (len_i == LW'(8) && off_i == 3'd0);
  assign wr_ok = (len_i != '0 && len_i <= LW'(4) && fit4 && !(len_one && mask_i == '0))
              || (len_i == LW'(8) && off_i == 3'd0);

  always_comb begin
    if (lock_i)    legal = len_one && (mask_i != '0);
    else if (wr_i) legal = wr_ok;
    else           legal = rd_ok;
  end

  assign region  = hi_i[1+BB -: 2];
  assign bank    = hi_i[BB-1:0];
  assign bank_on = bank_en_i[bank];
  assign is_rd   = lock_i || !wr_i;

  always_comb begin
    if (!legal)                             out_o = O_PERR;
    else if (region == RSV_CODE)            out_o = is_rd ? O_ABORT : O_DROP;
    else if (region == DRAM_CODE && !bank_on) begin
      if (len_one)                          out_o = O_REFRESH;
      else                                  out_o = is_rd ? O_ABORT : O_DROP;
    end
    else                                    out_o = O_BUS;
  end
endmodule

// File: rtl/mtd_seq.sv
module mtd_seq
  import mtd_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 4,
  parameter int BW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_lock_i,
  input  logic [LW-1:0] req_len_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [BW-1:0] req_mask_i,
  output logic          wr_q_o,
  output logic          lock_q_o,
  output logic [LW-1:0] len_q_o,
  output logic [AW-1:0] addr_q_o,
  output logic [BW-1:0] mask_q_o,
  input  mtd_out_e      out_i,
  input  logic          bus_ready_i,
  output logic          bus_valid_o,
  output logic          bus_write_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [BW-1:0] bus_mask_o,
  output logic          rd_beat_o,
  output logic          wd_take_o,
  output logic          zero_rd_o,
  output logic          perr_o,
  output logic          abort_o,
  output logic          refresh_o,
  output logic          done_o
);
  mtd_st_e       st_q;
  logic          wr_q, lock_q;
  logic [LW-1:0] len_q, cnt_q, len_m1;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] mask_q;
  logic          accept, dec, burst_st, beat, last_beat;

  assign req_ready_o = st_q == S_IDLE;
  assign accept      = req_valid_i && req_ready_o;
  assign dec         = st_q == S_DEC;
  assign burst_st    = (st_q == S_RD) || (st_q == S_WR);
  assign len_m1      = len_q - LW'(1);

  assign bus_valid_o = burst_st || (st_q == S_LK_RD) || (st_q == S_LK_WR);
  assign bus_write_o = (st_q == S_WR) || (st_q == S_LK_WR);
  assign bus_addr_o  = addr_q + AW'(cnt_q);
  assign bus_mask_o  = (st_q == S_LK_WR || (st_q == S_WR && len_q == LW'(1)))
                       ? mask_q : '1;

  assign beat      = bus_valid_o && bus_ready_i;
  assign last_beat = beat && ((st_q == S_LK_WR) || (burst_st && cnt_q == len_m1));
  assign rd_beat_o = beat && !bus_write_o;
  assign wd_take_o = beat && bus_write_o;

  assign perr_o    = dec && out_i == O_PERR;
  assign abort_o   = dec && out_i == O_ABORT;
  assign refresh_o = dec && out_i == O_REFRESH;
  assign zero_rd_o = refresh_o && (lock_q || !wr_q);
  assign done_o    = (dec && out_i != O_BUS) || last_beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      wr_q   <= 1'b0;
      lock_q <= 1'b0;
      len_q  <= '0;
      addr_q <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          st_q   <= S_DEC;
          wr_q   <= req_write_i;
          lock_q <= req_lock_i;
          len_q  <= req_len_i;
          addr_q <= req_addr_i;
          mask_q <= req_mask_i;
          cnt_q  <= '0;
        end
        S_DEC: begin
          if (out_i == O_BUS) begin
            if (lock_q)    st_q <= S_LK_RD;
            else if (wr_q) st_q <= S_WR;
            else           st_q <= S_RD;
          end else begin
            st_q <= S_IDLE;
          end
        end
        S_RD, S_WR: if (bus_ready_i) begin
          if (cnt_q == len_m1) st_q  <= S_IDLE;
          else                 cnt_q <= cnt_q + LW'(1);
        end
        S_LK_RD: if (bus_ready_i) st_q <= S_LK_WR;
        S_LK_WR: if (bus_ready_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign wr_q_o   = wr_q;
  assign lock_q_o = lock_q;
  assign len_q_o  = len_q;
  assign addr_q_o = addr_q;
  assign mask_q_o = mask_q;

  a_r10_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o)
                                    && $stable(bus_write_o) && $stable(bus_mask_o));

  a_r10_ascend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_st && beat && !last_beat |=> bus_valid_o && bus_addr_o == $past(bus_addr_o) + AW'(1));

  a_r4_swap_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_LK_RD && beat |=> bus_valid_o && bus_write_o && bus_addr_o == $past(bus_addr_o));

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o);

  a_r1_perr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |=> !perr_o && !bus_valid_o);

  a_r3_mask_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_write_o |-> bus_mask_o != '0);
endmodule

// File: rtl/mtd_data.sv
module mtd_data #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_beat_i,
  input  logic          wd_take_i,
  input  logic          zero_rd_i,
  input  logic          bus_sel_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] last_q;

  // last value seen on the shared data bus, either direction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       last_q <= '0;
    else if (wd_take_i)                last_q <= wdata_i;
    else if (rd_beat_i && bus_sel_i)   last_q <= bus_rdata_i;
  end

  assign rd_valid_o = rd_beat_i || zero_rd_i;

  always_comb begin
    if (zero_rd_i)      rd_data_o = '0;
    else if (bus_sel_i) rd_data_o = bus_rdata_i;
    else                rd_data_o = last_q;
  end

  a_r6_no_sel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_beat_i && !bus_sel_i |=> $stable(last_q));
endmodule

// File: rtl/mem_txn_dispatch.sv
module mem_txn_dispatch
  import mtd_pkg::*;
#(
  parameter int AW    = 12,
  parameter int LW    = 4,
  parameter int DW    = 32,
  parameter int NBANK = 4,
  localparam int BW = DW / 8,
  localparam int BB = $clog2(NBANK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_lock_i,
  input  logic [LW-1:0]    req_len_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [BW-1:0]    req_mask_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             wd_take_o,
  input  logic [NBANK-1:0] bank_en_i,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic             bus_write_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [BW-1:0]    bus_mask_o,
  output logic [DW-1:0]    bus_wdata_o,
  input  logic [DW-1:0]    bus_rdata_i,
  input  logic             bus_sel_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             abort_o,
  output logic             perr_o,
  output logic             refresh_o,
  output logic             done_o
);
  logic          wr_q, lock_q, rd_beat, zero_rd;
  logic [LW-1:0] len_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] mask_q;
  mtd_out_e      outcome;

  mtd_seq #(.AW(AW), .LW(LW), .BW(BW)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_lock_i,
    .req_len_i, .req_addr_i, .req_mask_i,
    .wr_q_o(wr_q), .lock_q_o(lock_q), .len_q_o(len_q), .addr_q_o(addr_q),
    .mask_q_o(mask_q), .out_i(outcome), .bus_ready_i, .bus_valid_o,
    .bus_write_o, .bus_addr_o, .bus_mask_o, .rd_beat_o(rd_beat),
    .wd_take_o, .zero_rd_o(zero_rd), .perr_o, .abort_o, .refresh_o, .done_o
  );

  mtd_decode #(.LW(LW), .BW(BW), .NBANK(NBANK)) u_dec (
    .wr_i(wr_q), .lock_i(lock_q), .len_i(len_q), .off_i(addr_q[2:0]),
    .hi_i(addr_q[AW-1 -: 2+BB]), .mask_i(mask_q), .bank_en_i,
    .out_o(outcome)
  );

  mtd_data #(.DW(DW)) u_data (
    .clk_i, .rst_ni, .rd_beat_i(rd_beat), .wd_take_i(wd_take_o),
    .zero_rd_i(zero_rd), .bus_sel_i, .bus_rdata_i, .wdata_i,
    .rd_valid_o, .rd_data_o
  );

  assign bus_wdata_o = wdata_i;

  a_r7_zero_on_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && refresh_o |-> rd_data_o == '0 && !bus_valid_o);
endmodule

// File: tb/sim_mem_txn_dispatch.sv
module sim_mem_txn_dispatch;
  localparam int AW = 12, LW = 4, DW = 32, NBANK = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_lock = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_mask = '0;
  logic [DW-1:0] wdata, bus_wdata, bus_rdata, rd_data;
  logic wd_take, bus_valid, bus_ready, bus_write, bus_sel, rd_valid;
  logic abort, perr, refresh, done;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_mask;
  logic [NBANK-1:0] bank_en = 4'b0101;

  logic [7:0] lf = 8'h5A;
  logic rdy_all = 1'b0;
  always @(posedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  assign bus_ready = rdy_all | (lf[1:0] != 2'b00);
  assign bus_sel   = bus_addr[11:10] != 2'b11;
  assign bus_rdata = {20'hB5A50, bus_addr};
  assign wdata     = {20'hC0DE0, bus_addr};

  mem_txn_dispatch u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_lock_i(req_lock), .req_len_i(req_len),
    .req_addr_i(req_addr), .req_mask_i(req_mask), .wdata_i(wdata),
    .wd_take_o(wd_take), .bank_en_i(bank_en), .bus_valid_o(bus_valid),
    .bus_ready_i(bus_ready), .bus_write_o(bus_write), .bus_addr_o(bus_addr),
    .bus_mask_o(bus_mask), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_sel_i(bus_sel), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .abort_o(abort), .perr_o(perr), .refresh_o(refresh), .done_o(done)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] last_m = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++; n_chk++;
      $display("FAIL R9 watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // kinds: 0 perr, 1 abort, 2 drop, 3 refresh, 4 bus
  task automatic run(input logic wr, input logic lk, input int len,
                     input logic [AW-1:0] addr, input logic [3:0] mask);
    int off, o4, rg, bk, kind, nb_exp, np, na, nr, nv, nb, nz, dn;
    logic legal, isrd;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    string lt;
    off = int'(addr[2:0]); o4 = off % 4;
    rg = int'(addr[11:10]); bk = int'(addr[9:8]);
    isrd = lk || !wr;
    if (lk)      begin legal = (len == 1) && (mask != 0); lt = "R4"; end
    else if (wr) begin
      legal = ((len >= 1 && len <= 4 && o4 + len <= 4) || (len == 8 && off == 0))
              && !(len == 1 && mask == 0);
      lt = "R2";
    end else begin
      legal = (len == 1) || (len == 4 && o4 == 0) || (len == 8 && off == 0);
      lt = "R1";
    end
    if (!legal) kind = 0;
    else if (rg == 2) kind = isrd ? 1 : 2;
    else if (rg == 0 && !bank_en[bk]) kind = (len == 1) ? 3 : (isrd ? 1 : 2);
    else kind = 4;
    nb_exp = (kind == 4) ? (lk ? 2 : len) : 0;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_lock = lk;
    req_len = LW'(len); req_addr = addr; req_mask = mask;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    np = 0; na = 0; nr = 0; nv = 0; nb = 0; nz = 0; dn = 0;
    for (int c = 0; c < 200; c++) begin
      if (perr) np++;
      if (abort) na++;
      if (refresh) nr++;
      if (bus_valid) nv++;
      if (bus_valid && bus_ready) begin
        ea = lk ? addr : addr + AW'(nb);
        chk("R10 beat address", 64'(bus_addr), 64'(ea));
        chk("R4 beat direction", 64'(bus_write), lk ? 64'(nb == 1) : 64'(wr));
        chk("R3 beat mask", 64'(bus_mask),
            ((lk && nb == 1) || (wr && !lk && len == 1)) ? 64'(mask) : 64'hF);
        if (bus_write) begin
          chk("R10 write take", 64'(wd_take), 64'd1);
          chk("R10 write data", 64'(bus_wdata), 64'({20'hC0DE0, ea}));
          last_m = {20'hC0DE0, ea};
        end else begin
          ed = (rg != 3) ? {20'hB5A50, ea} : last_m;
          chk("R10 read valid", 64'(rd_valid), 64'd1);
          chk(rg == 3 ? "R6 last bus value" : "R10 read data", 64'(rd_data), 64'(ed));
          if (rg != 3) last_m = ed;
        end
        nb++;
      end
      if (rd_valid && !bus_valid) begin
        nz++;
        chk("R7 zero read data", 64'(rd_data), 64'd0);
      end
      if (done) begin dn = 1; break; end
      @(negedge clk);
    end
    chk("R9 done seen", 64'(dn), 64'd1);
    chk({lt, " perr count"}, 64'(np), 64'(kind == 0));
    chk("R5 R8 abort count", 64'(na), 64'(kind == 1));
    chk("R7 refresh count", 64'(nr), 64'(kind == 3));
    chk("R7 zero read count", 64'(nz), 64'(kind == 3 && isrd));
    chk("R10 beat count", 64'(nb), 64'(nb_exp));
    if (kind != 4) chk("R5 R8 no bus valid", 64'(nv), 64'd0);
    @(negedge clk);
    chk("R9 ready after done", 64'(req_ready), 64'd1);
    chk("R9 single done", 64'(done), 64'd0);
  endtask

  task automatic region_sweep();
    for (int rg = 0; rg < 4; rg++)
      for (int bk = 0; bk < 4; bk++) begin
        logic [AW-1:0] a;
        a = {2'(rg), 2'(bk), 5'h03, 3'b000};
        run(1'b0, 1'b0, 1, a, 4'hF);
        run(1'b0, 1'b0, 4, a, 4'hF);
        run(1'b1, 1'b0, 1, a, 4'h6);
        run(1'b1, 1'b0, 4, a, 4'hF);
        run(1'b0, 1'b1, 1, a + AW'(2), 4'h9);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset ready", 64'(req_ready), 64'd1);
    chk("R11 reset bus idle", 64'(bus_valid), 64'd0);
    chk("R11 reset pulses", 64'({done, perr, abort, refresh, rd_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 length/offset sweep in an ordinary device region
    for (int w = 0; w < 2; w++)
      for (int len = 0; len < 10; len++)
        for (int off = 0; off < 8; off++)
          run(1'(w), 1'b0, len, {2'b01, 2'b00, 5'h0A, 3'(off)}, 4'hF);

    // R3 single-write masks including zero
    for (int m = 0; m < 16; m++)
      run(1'b1, 1'b0, 1, {2'b01, 2'b10, 5'h11, 3'd3}, 4'(m));

    // R4 swap lengths and masks, populated and unpopulated
    for (int len = 0; len < 5; len++) begin
      run(1'b0, 1'b1, len, {2'b01, 2'b01, 5'h05, 3'd6}, 4'h3);
      run(1'b1, 1'b1, len, {2'b11, 2'b01, 5'h05, 3'd1}, 4'hC);
    end
    run(1'b0, 1'b1, 1, {2'b01, 2'b01, 5'h05, 3'd6}, 4'h0);

    // R6 write then read with no device selected
    run(1'b1, 1'b0, 1, {2'b11, 2'b00, 5'h1F, 3'd2}, 4'hF);
    run(1'b0, 1'b0, 1, {2'b11, 2'b00, 5'h01, 3'd5}, 4'hF);
    run(1'b0, 1'b0, 8, {2'b11, 2'b00, 5'h02, 3'd0}, 4'hF);

    // R5 R7 R8 regions and banks, stalled and unstalled bus
    region_sweep();
    rdy_all = 1'b1;
    region_sweep();
    for (int len = 1; len < 9; len++)
      run(1'b0, 1'b0, len, {2'b00, 2'b10, 5'h07, 3'd0}, 4'hF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule